// File: doc/BRIEF.md
# Programmable I/O Bus Cycle Sequencer

This block runs external I/O reads and writes one at a time on behalf of a processor-side requester. Each request carries its own bus timing in a nine-bit field of the I/O address (bits 11 down to 3). The field sets how many address setup cycles come first, how long the strobe phase lasts, how many bus hold cycles follow, whether an external wait line may stretch the access, and which strobe signalling the device expects.

The requester raises `req_valid` with address, direction and write data, and keeps them steady until `req_ack` pulses; it drops `req_valid` in the cycle after the pulse. On the device side the block drives the full request address, write data with its output enable, and two active-low strobe pins. In separate-strobe mode one pin strobes reads and the other writes. In data-strobe mode the first pin strobes both directions and the second pin gives the transfer direction. The wait line passes through a synchroniser and is interpreted according to a polarity input.

Top module: `io_cycle_seq`

## Requirements
- R1: After reset `io_rd_n` and `io_wr_n` are high, `io_dout_en` is low and `req_ack` is low.
- R2: The timing field is decoded as follows. Address bit 11 enables the wait line and bit 10 selects data-strobe mode. Bits 9..8 give setup cycles of 0, 2, 4 or 8 for codes 0 to 3. Bits 7..5 give 2×(code+1) access cycles. Bits 4..3 give hold cycles of 0, 2, 4 or 6. `io_addr` carries the whole request address from the first cycle after acceptance.
- R3: All setup cycles come before the access phase. The active strobe is high in the first access cycle and low in every later access cycle. Counting the cycle after acceptance as index 0, the strobe therefore first goes low at index S+1 and stays low for N−1 cycles.
- R4: Hold cycles follow the access phase. `req_ack` is high for exactly one cycle, at index S+N+H, where N is the final access length.
- R5: In separate-strobe mode (bit 10 = 0), a read pulls only `io_rd_n` low and a write pulls only `io_wr_n` low.
- R6: In data-strobe mode (bit 10 = 1), `io_rd_n` is the strobe for both directions. `io_wr_n` gives the direction: it is low through the setup, access and hold cycles of a write and stays high for a read.
- R7: `io_dout_en` is high in exactly the N access cycles of a write, and it never rises during a read. `io_dout` then carries the request's write data.
- R8: Read data on `io_din` is captured at the end of the last access cycle and is presented on `rsp_rdata` when `req_ack` is high.
- R9: With bit 11 clear, `io_wait` has no effect on cycle length.
- R10: With bit 11 set, the access phase continues for as long as the synchronised wait is asserted. A change on `io_wait` takes effect two cycles later. The access phase lasts at least four cycles even when the encoded length is two.
- R11: When `wait_pol` is 1, a high level on `io_wait` asserts wait. When `wait_pol` is 0, a low level asserts wait.
- R12: A request is accepted only when the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_pol | input | 1 | Wait polarity: 1 means active-high, 0 means active-low |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | I/O address, with the timing field in bits 11..3 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| io_addr | output | ADDR_W | Device address |
| io_dout | output | DATA_W | Device write data |
| io_dout_en | output | 1 | Write data output enable |
| io_din | input | DATA_W | Device read data |
| io_rd_n | output | 1 | Read strobe, or data strobe in data-strobe mode |
| io_wr_n | output | 1 | Write strobe, or direction in data-strobe mode |
| io_wait | input | 1 | Asynchronous wait line from the device |

## Verification
A wrong phase counter or a wrong field decode moves the strobe edges. The fault shows on the pins within the same transfer: the first strobe-low index, the length of the low window and the acknowledge index all shift. A stuck or misrouted wait path shows as an access that ends too early or does not end, and this is visible within two cycles of the wait edge. A wrong strobe-mode decode shows on the first strobe cycle as the wrong pin going low or as a direction level that is missing.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

  localparam int LEN_W        = 5;
  localparam int FIELD_LSB    = 3;
  localparam int FIELD_W      = 9;
  localparam int MIN_WAIT_ACC = 4;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACCESS = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  typedef struct packed {
    logic             wait_en;
    logic             ds_mode;
    logic [LEN_W-1:0] setup_len;
    logic [LEN_W-1:0] acc_len;
    logic [LEN_W-1:0] hold_len;
  } io_timing_t;

endpackage

// File: rtl/io_timing_decode.sv
module io_timing_decode
  import io_seq_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  output io_timing_t         cfg
);

  logic [1:0]       setup_code;
  logic [2:0]       acc_code;
  logic [1:0]       hold_code;
  logic [LEN_W-1:0] acc_raw;

  assign setup_code = field[6:5];
  assign acc_code   = field[4:2];
  assign hold_code  = field[1:0];

  always_comb begin
    cfg.wait_en = field[8];
    cfg.ds_mode = field[7];

    unique case (setup_code)
      2'd0:    cfg.setup_len = LEN_W'(0);
      2'd1:    cfg.setup_len = LEN_W'(2);
      2'd2:    cfg.setup_len = LEN_W'(4);
      default: cfg.setup_len = LEN_W'(8);
    endcase

    acc_raw = LEN_W'({acc_code, 1'b0}) + LEN_W'(2);
    if (field[8] && (acc_raw < LEN_W'(MIN_WAIT_ACC)))
      cfg.acc_len = LEN_W'(MIN_WAIT_ACC);
    else
      cfg.acc_len = acc_raw;

    cfg.hold_len = LEN_W'({hold_code, 1'b0});
  end

endmodule

// File: rtl/io_wait_sync.sv
module io_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_in,
  input  logic pol,
  output logic wait_act
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = wait_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], wait_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign wait_act = ~(sync_q[STAGES-1] ^ pol);

endmodule

// File: rtl/io_phase_ctrl.sv
module io_phase_ctrl
  import io_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  io_timing_t req_cfg,
  input  logic       wait_act,
  output phase_e     phase,
  output io_timing_t cfg,
  output logic       strobe_on,
  output logic       acc_end,
  output logic       ack
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  io_timing_t       cfg_q;
  logic             cfg_en;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] setup_n, acc_n, hold_n;
  logic             wait_hold;

  assign setup_n   = CNT_W'(cfg_q.setup_len);
  assign acc_n     = CNT_W'(cfg_q.acc_len);
  assign hold_n    = CNT_W'(cfg_q.hold_len);
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
  assign wait_hold = cfg_q.wait_en && wait_act;
  assign cfg_en    = start && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    acc_end = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = (req_cfg.setup_len != '0) ? PH_SETUP : PH_ACCESS;
          cnt_d   = CNT_ONE;
        end
      end
      PH_SETUP: begin
        if (cnt_q >= setup_n) begin
          phase_d = PH_ACCESS;
          cnt_d   = CNT_ONE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_ACCESS: begin
        if ((cnt_q >= acc_n) && !wait_hold) begin
          acc_end = 1'b1;
          phase_d = (hold_n != '0) ? PH_HOLD : PH_DONE;
          cnt_d   = CNT_ONE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_HOLD: begin
        if (cnt_q >= hold_n) begin
          phase_d = PH_DONE;
          cnt_d   = CNT_ONE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PH_DONE: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= req_cfg;
  end

  assign phase     = phase_q;
  assign cfg       = cfg_q;
  assign strobe_on = (phase_q == PH_ACCESS) && (cnt_q >= CNT_W'(2));
  assign ack       = (phase_q == PH_DONE);

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R10
  acc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACCESS && wait_hold) |=> (phase_q == PH_ACCESS));

  // R10
  acc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end && cfg_q.wait_en) |-> (cnt_q >= CNT_W'(MIN_WAIT_ACC)));

  // R3
  setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_SETUP || phase_q == PH_ACCESS));

endmodule

// File: rtl/io_pin_drive.sv
module io_pin_drive
  import io_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   ds_mode,
  input  logic   write,
  input  logic   strobe_on,
  output logic   rd_n,
  output logic   wr_n,
  output logic   dout_en
);

  logic busy;

  assign busy = (phase == PH_SETUP) || (phase == PH_ACCESS) || (phase == PH_HOLD);

  always_comb begin
    if (ds_mode) begin
      rd_n = ~strobe_on;
      wr_n = ~(busy && write);
    end else begin
      rd_n = ~(strobe_on && !write);
      wr_n = ~(strobe_on && write);
    end
    dout_en = (phase == PH_ACCESS) && write;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_mode |-> (rd_n || wr_n));

  // R3
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (phase == PH_ACCESS));

  // R7
  dout_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> write);

endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
  import io_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_pol,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_dout,
  output logic              io_dout_en,
  input  logic [DATA_W-1:0] io_din,
  output logic              io_rd_n,
  output logic              io_wr_n,
  input  logic              io_wait
);

  localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  phase_e            phase;
  io_timing_t        req_cfg;
  io_timing_t        cfg;
  logic              wait_act;
  logic              start;
  logic              strobe_on;
  logic              acc_end;
  logic              ack;
  logic              rdata_en;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  assign start    = req_valid && (phase == PH_IDLE);
  assign rdata_en = acc_end && !write_q;

  io_timing_decode u_decode (
    .field (req_addr[FIELD_MSB:FIELD_LSB]),
    .cfg   (req_cfg)
  );

  io_wait_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_in  (io_wait),
    .pol      (wait_pol),
    .wait_act (wait_act)
  );

  io_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_cfg   (req_cfg),
    .wait_act  (wait_act),
    .phase     (phase),
    .cfg       (cfg),
    .strobe_on (strobe_on),
    .acc_end   (acc_end),
    .ack       (ack)
  );

  io_pin_drive u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .ds_mode   (cfg.ds_mode),
    .write     (write_q),
    .strobe_on (strobe_on),
    .rd_n      (io_rd_n),
    .wr_n      (io_wr_n),
    .dout_en   (io_dout_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= io_din;
  end

  assign req_ack   = ack;
  assign rsp_rdata = rdata_q;
  assign io_addr   = addr_q;
  assign io_dout   = wdata_q;

  // R12
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(addr_q));

endmodule

// File: tb/io_cycle_seq_test.sv
`timescale 1ns/1ps
module io_cycle_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wait_pol = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_ack;
  logic [31:0] rsp_rdata;
  logic [31:0] io_addr;
  logic [31:0] io_dout;
  logic        io_dout_en;
  logic [31:0] io_din = '0;
  logic        io_rd_n;
  logic        io_wr_n;
  logic        io_wait = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  int m_rd_first, m_rd_cnt, m_wr_first, m_wr_cnt, m_dout_cnt, m_ack_idx;
  logic [31:0] m_addr0, m_rdata, m_dout;

  always #2.5 clk = ~clk;

  io_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .wait_pol(wait_pol), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .io_addr(io_addr),
    .io_dout(io_dout), .io_dout_en(io_dout_en), .io_din(io_din),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wait(io_wait)
  );

  function automatic logic [31:0] mk(input logic [19:0] hi, input logic we, input logic md,
                                     input logic [1:0] s, input logic [2:0] a, input logic [1:0] h);
    return {hi, we, md, s, a, h, 3'b101};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [31:0] addr, input logic wr, input logic [31:0] wd,
                          input logic [31:0] din, input int rel_j, input logic rel_val);
    @(negedge clk);
    req_addr = addr; req_write = wr; req_wdata = wd; io_din = din; req_valid = 1'b1;
    m_rd_first = -1; m_rd_cnt = 0; m_wr_first = -1; m_wr_cnt = 0;
    m_dout_cnt = 0; m_ack_idx = -1; m_addr0 = '0; m_rdata = '0; m_dout = '0;
    @(posedge clk);
    for (int idx = 0; idx < 300; idx++) begin
      @(negedge clk);
      if (idx == 0) m_addr0 = io_addr;
      if (!io_rd_n) begin if (m_rd_first < 0) m_rd_first = idx; m_rd_cnt++; end
      if (!io_wr_n) begin if (m_wr_first < 0) m_wr_first = idx; m_wr_cnt++; end
      if (io_dout_en) begin m_dout_cnt++; m_dout = io_dout; end
      if (idx == rel_j) io_wait = rel_val;
      if (req_ack) begin m_ack_idx = idx; m_rdata = rsp_rdata; break; end
    end
    req_valid = 1'b0;
    if (m_ack_idx < 0) chk("R4", "transfer hung, ack index", -1, 0);
  endtask

  task automatic t_reset();
    chk("R1", "rd_n at reset", io_rd_n, 1);
    chk("R1", "wr_n at reset", io_wr_n, 1);
    chk("R1", "dout_en at reset", io_dout_en, 0);
    chk("R1", "ack at reset", req_ack, 0);
  endtask

  task automatic t_sep_read();
    logic [31:0] a;
    a = mk(20'h12345, 1'b0, 1'b0, 2'd1, 3'd2, 2'd1);
    run_xfer(a, 1'b0, 32'h0, 32'hCAFE_0123, -1, 1'b0);
    chk("R2", "address on bus", m_addr0, a);
    chk("R3", "rd first low idx", m_rd_first, 3);
    chk("R3", "rd low count", m_rd_cnt, 5);
    chk("R5", "wr low count on read", m_wr_cnt, 0);
    chk("R7", "dout_en on read", m_dout_cnt, 0);
    chk("R4", "ack idx", m_ack_idx, 10);
    chk("R8", "read data", m_rdata, 32'hCAFE_0123);
  endtask

  task automatic t_sep_write();
    logic [31:0] a;
    a = mk(20'h00F0F, 1'b0, 1'b0, 2'd0, 3'd7, 2'd3);
    run_xfer(a, 1'b1, 32'h5A5A_A5A5, 32'h0, -1, 1'b0);
    chk("R5", "wr first low idx", m_wr_first, 1);
    chk("R2", "wr low count (16 access)", m_wr_cnt, 15);
    chk("R5", "rd low count on write", m_rd_cnt, 0);
    chk("R7", "dout_en count", m_dout_cnt, 16);
    chk("R7", "write data", m_dout, 32'h5A5A_A5A5);
    chk("R4", "ack idx with hold 6", m_ack_idx, 22);
  endtask

  task automatic t_ds_read();
    logic [31:0] a;
    a = mk(20'hABCDE, 1'b0, 1'b1, 2'd3, 3'd0, 2'd2);
    run_xfer(a, 1'b0, 32'h0, 32'h0BAD_F00D, -1, 1'b0);
    chk("R3", "ds rd first low idx (setup 8)", m_rd_first, 9);
    chk("R6", "ds rd low count", m_rd_cnt, 1);
    chk("R6", "direction high on read", m_wr_cnt, 0);
    chk("R4", "ack idx", m_ack_idx, 14);
    chk("R8", "ds read data", m_rdata, 32'h0BAD_F00D);
  endtask

  task automatic t_ds_write();
    logic [31:0] a;
    a = mk(20'h00001, 1'b0, 1'b1, 2'd2, 3'd3, 2'd0);
    run_xfer(a, 1'b1, 32'h1357_9BDF, 32'h0, -1, 1'b0);
    chk("R6", "ds strobe first low idx", m_rd_first, 5);
    chk("R6", "ds strobe low count", m_rd_cnt, 7);
    chk("R6", "direction low first idx", m_wr_first, 0);
    chk("R6", "direction low count", m_wr_cnt, 12);
    chk("R7", "ds dout_en count", m_dout_cnt, 8);
    chk("R4", "ack idx no hold", m_ack_idx, 12);
  endtask

  task automatic t_wait_ignored();
    wait_pol = 1'b1; io_wait = 1'b1; settle();
    run_xfer(mk(20'h0, 1'b0, 1'b0, 2'd0, 3'd1, 2'd0), 1'b0, 32'h0, 32'h0, -1, 1'b0);
    chk("R9", "ack idx with wait disabled", m_ack_idx, 4);
    chk("R9", "rd low count", m_rd_cnt, 3);
    io_wait = 1'b0; settle();
  endtask

  task automatic t_wait_extend();
    wait_pol = 1'b1; io_wait = 1'b1; settle();
    run_xfer(mk(20'h0, 1'b1, 1'b0, 2'd0, 3'd1, 2'd0), 1'b0, 32'h0, 32'h77, 8, 1'b0);
    chk("R10", "ack idx after wait release", m_ack_idx, 11);
    chk("R10", "rd low count extended", m_rd_cnt, 10);
    chk("R8", "read data after wait", m_rdata, 32'h77);
    settle();
  endtask

  task automatic t_wait_floor();
    wait_pol = 1'b1; io_wait = 1'b0; settle();
    run_xfer(mk(20'h0, 1'b1, 1'b0, 2'd0, 3'd0, 2'd0), 1'b0, 32'h0, 32'h0, -1, 1'b0);
    chk("R10", "ack idx at four-cycle floor", m_ack_idx, 4);
    chk("R10", "rd low count at floor", m_rd_cnt, 3);
  endtask

  task automatic t_wait_early();
    wait_pol = 1'b1; io_wait = 1'b1; settle();
    run_xfer(mk(20'h0, 1'b1, 1'b0, 2'd0, 3'd2, 2'd0), 1'b0, 32'h0, 32'h0, 0, 1'b0);
    chk("R10", "early release keeps nominal length", m_ack_idx, 6);
    settle();
  endtask

  task automatic t_wait_low_pol();
    wait_pol = 1'b0; io_wait = 1'b0; settle();
    run_xfer(mk(20'h0, 1'b1, 1'b0, 2'd0, 3'd1, 2'd0), 1'b0, 32'h0, 32'h0, 5, 1'b1);
    chk("R11", "active-low wait ack idx", m_ack_idx, 8);
    chk("R11", "active-low wait rd low count", m_rd_cnt, 7);
    settle();
    wait_pol = 1'b1; io_wait = 1'b0; settle();
  endtask

  task automatic t_busy_accept();
    // R12: request stays up through the transfer; exactly one ack is produced
    int acks;
    acks = 0;
    @(negedge clk);
    req_addr = mk(20'h0, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0); req_write = 1'b0; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (req_ack) acks++;
    end
    req_valid = 1'b0;
    repeat (4) @(negedge clk) if (req_ack) acks++;
    chk("R12", "ack count for held request", acks, 1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_sep_read();
    t_sep_write();
    t_ds_read();
    t_ds_write();
    t_wait_ignored();
    t_wait_extend();
    t_wait_floor();
    t_wait_early();
    t_wait_low_pol();
    t_busy_accept();
    settle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule